// File: doc/BRIEF.md
# Handshaked Parallel Port Controller

This block manages three general purpose parallel ports that share one register interface: two full-width ports (A and B) and a six-bit port C. A single control byte fixes the direction of A and B, selects how port C is used, and arms the interrupt flags of A and B. Port C can be a plain input port or a plain output port. It can also give its pins to strobed handshake lines for port A, or for both A and B. In that role each handshaked port gets an interrupt line, a buffer-full line and a strobe input.

A host writes the control byte, writes output data and reads port data or the status byte through a select code, a write strobe and a read strobe. Read data is registered and shows up in the cycle after the read strobe. A read or write that the register interface sees is also the event that drives the handshake flags.

Top module: `pport_ctrl`

## Requirements
- R1: A write with select 0 loads the control byte. Bit 0 gives the direction of port A and bit 1 the direction of port B (0 input, 1 output). The direction enables pa_oe and pb_oe follow in the next cycle.
- R2: Control bits 3:2 choose the port C use: 00 all six pins input (pc_oe 6'h00), 11 all pins output (6'h3F), 01 port A handshake (6'h3B), 10 handshake for A and B (6'h1B).
- R3: While a port is in input mode its output latch stays zero, and writes to it are dropped. A port switched from input to output therefore drives all zeros.
- R4: Reading port A (select 1), B (select 2) or C (select 3) returns the latch for output bits. Plain input bits return the pin levels.
- R5: After the synchronous reset every latch is zero, all three ports are inputs, and port C is in plain input use.
- R6: Under handshake, port A uses PC0 as INTR, PC1 as BF and PC2 as STB, and port B uses PC3, PC4 and PC5 the same way. A control write that enables handshake starts BF low, and starts INTR low for an input port or high for an output port.
- R7: Strobed input: while STB is low the pin data is captured and BF is set. A rising STB sets INTR when that port's interrupt enable is on. A read of the port returns the captured data and clears INTR and BF.
- R8: Strobed output: a write to the port loads the latch, sets BF and clears INTR. STB low clears BF. A rising STB sets INTR when the interrupt enable is on.
- R9: A read with select 0 returns the status byte: bit0 A INTR, bit1 A BF, bit2 A interrupt enable (control bit 4), bit3 B INTR, bit4 B BF, bit5 B interrupt enable (control bit 5), bits 7:6 zero.
- R10: With the interrupt enable off, a completed strobe still sets BF but leaves INTR low.
- R11: In plain output use every port C pin drives its latch bit. In port A handshake use, PC3 to PC5 stay plain outputs driven from latch bits 3 to 5.
- R12: reg_rdata changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 control/status, 1 A, 2 B, 3 C |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Registered read data |
| pa_in | input | BUS_W | Port A pin levels |
| pa_out | output | BUS_W | Port A output latch |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | BUS_W | Port B pin levels |
| pb_out | output | BUS_W | Port B output latch |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 6 | Port C pin levels, strobes included |
| pc_out | output | 6 | Port C pin drive values |
| pc_oe | output | 6 | Port C per-pin drive enables |

## Verification
The hardest state to reach is a handshake flag pair that changes under a strobe rather than under a register access. The stimulus first selects handshake use with a control write, then holds the strobe pin low across a clock edge while the pin data is valid. It changes the data before it releases the strobe, so the capture point can be observed, and it reads the status byte before and after the port read that clears the flags. It repeats the strobe with the interrupt enable off, and again on port B in output mode after a host write has set BF.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PC_W = 6;

  typedef enum logic [1:0] {
    PC_PLAIN_IN  = 2'b00,
    PC_HS_A      = 2'b01,
    PC_HS_AB     = 2'b10,
    PC_PLAIN_OUT = 2'b11
  } pc_mode_e;

  typedef enum logic [1:0] {
    SEL_CS = 2'd0,
    SEL_A  = 2'd1,
    SEL_B  = 2'd2,
    SEL_C  = 2'd3
  } reg_sel_e;

  function automatic logic hs_on_a(input pc_mode_e m);
    return (m == PC_HS_A) || (m == PC_HS_AB);
  endfunction

  function automatic logic hs_on_b(input pc_mode_e m);
    return (m == PC_HS_AB);
  endfunction

  function automatic logic [PC_W-1:0] pc_drive_mask(input pc_mode_e m);
    case (m)
      PC_PLAIN_OUT: return 6'b111111;
      PC_HS_A:      return 6'b111011;
      PC_HS_AB:     return 6'b011011;
      default:      return 6'b000000;
    endcase
  endfunction

  function automatic logic [PC_W-1:0] pc_plain_mask(input pc_mode_e m);
    case (m)
      PC_PLAIN_OUT: return 6'b111111;
      PC_HS_A:      return 6'b111000;
      default:      return 6'b000000;
    endcase
  endfunction
endpackage

// File: rtl/pport_lane.sv
module pport_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_we,
  input  logic         dir_q,
  input  logic         dir_nxt,
  input  logic         hs_q,
  input  logic         hs_nxt,
  input  logic         inte,
  input  logic         wr,
  input  logic         rd,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin,
  input  logic         stb,
  output logic [W-1:0] out_q,
  output logic [W-1:0] rd_val,
  output logic         bf,
  output logic         intr
);
  logic [W-1:0] cap_q;
  logic         stb_q;
  logic         stb_rise;

  assign stb_rise = hs_q && stb && !stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      cap_q <= '0;
      bf    <= 1'b0;
      intr  <= 1'b0;
      stb_q <= 1'b1;
    end else begin
      stb_q <= hs_q ? stb : 1'b1;
      if (!dir_nxt) out_q <= '0;
      else if (wr)  out_q <= wdata;
      if (cmd_we) begin
        bf   <= 1'b0;
        intr <= hs_nxt && dir_nxt;
      end else if (hs_q) begin
        if (!dir_q) begin
          if (rd) begin
            bf   <= 1'b0;
            intr <= 1'b0;
          end
          if (!stb) begin
            cap_q <= pin;
            bf    <= 1'b1;
          end
          if (stb_rise && inte) intr <= 1'b1;
        end else begin
          if (!stb) bf <= 1'b0;
          if (stb_rise && inte) intr <= 1'b1;
          if (wr) begin
            bf   <= 1'b1;
            intr <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    if (dir_q)     rd_val = out_q;
    else if (hs_q) rd_val = cap_q;
    else           rd_val = pin;
  end
endmodule

// File: rtl/pport_portc.sv
module pport_portc
  import pport_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  pc_mode_e        mode_q,
  input  pc_mode_e        mode_nxt,
  input  logic            wr,
  input  logic [PC_W-1:0] wdata,
  input  logic [PC_W-1:0] pc_in,
  input  logic            a_intr,
  input  logic            a_bf,
  input  logic            b_intr,
  input  logic            b_bf,
  output logic [PC_W-1:0] pc_out,
  output logic [PC_W-1:0] pc_oe,
  output logic            stb_a,
  output logic            stb_b,
  output logic [PC_W-1:0] rd_val
);
  logic [PC_W-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst)     latch_q <= '0;
    else if (wr) latch_q <= wdata & pc_plain_mask(mode_q);
    else         latch_q <= latch_q & pc_plain_mask(mode_nxt);
  end

  always_comb begin
    pc_out = latch_q & pc_plain_mask(mode_q);
    if (hs_on_a(mode_q)) begin
      pc_out[0] = a_intr;
      pc_out[1] = a_bf;
    end
    if (hs_on_b(mode_q)) begin
      pc_out[3] = b_intr;
      pc_out[4] = b_bf;
    end
  end

  assign pc_oe  = pc_drive_mask(mode_q);
  assign stb_a  = hs_on_a(mode_q) ? pc_in[2] : 1'b1;
  assign stb_b  = hs_on_b(mode_q) ? pc_in[5] : 1'b1;
  assign rd_val = (pc_out & pc_oe) | (pc_in & ~pc_oe);
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic [BUS_W-1:0] pa_in,
  output logic [BUS_W-1:0] pa_out,
  output logic             pa_oe,
  input  logic [BUS_W-1:0] pb_in,
  output logic [BUS_W-1:0] pb_out,
  output logic             pb_oe,
  input  logic [PC_W-1:0]  pc_in,
  output logic [PC_W-1:0]  pc_out,
  output logic [PC_W-1:0]  pc_oe
);
  localparam int NLANE = 2;
  localparam int CMD_W = 6;
  localparam int INTE0 = 4;

  logic [CMD_W-1:0] cmd_q, cmd_nxt;
  logic             cmd_we;
  pc_mode_e         mode_q, mode_nxt;

  logic [NLANE-1:0] hs_q, hs_nxt, stb, bf, intr, lane_wr, lane_rd;
  logic [BUS_W-1:0] lane_pin  [NLANE];
  logic [BUS_W-1:0] lane_out  [NLANE];
  logic [BUS_W-1:0] lane_rval [NLANE];
  logic [PC_W-1:0]  pc_rval;

  assign cmd_we   = reg_wr && (reg_sel == SEL_CS);
  assign cmd_nxt  = cmd_we ? reg_wdata[CMD_W-1:0] : cmd_q;
  assign mode_q   = pc_mode_e'(cmd_q[3:2]);
  assign mode_nxt = pc_mode_e'(cmd_nxt[3:2]);

  always_ff @(posedge clk) begin
    if (rst) cmd_q <= '0;
    else     cmd_q <= cmd_nxt;
  end

  assign hs_q   = {hs_on_b(mode_q),   hs_on_a(mode_q)};
  assign hs_nxt = {hs_on_b(mode_nxt), hs_on_a(mode_nxt)};
  assign lane_pin[0] = pa_in;
  assign lane_pin[1] = pb_in;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign lane_wr[i] = reg_wr && (reg_sel == 2'(i + 1));
    assign lane_rd[i] = reg_rd && (reg_sel == 2'(i + 1));
    pport_lane #(.W(BUS_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .cmd_we  (cmd_we),
      .dir_q   (cmd_q[i]),
      .dir_nxt (cmd_nxt[i]),
      .hs_q    (hs_q[i]),
      .hs_nxt  (hs_nxt[i]),
      .inte    (cmd_q[INTE0 + i]),
      .wr      (lane_wr[i]),
      .rd      (lane_rd[i]),
      .wdata   (reg_wdata),
      .pin     (lane_pin[i]),
      .stb     (stb[i]),
      .out_q   (lane_out[i]),
      .rd_val  (lane_rval[i]),
      .bf      (bf[i]),
      .intr    (intr[i])
    );
  end

  pport_portc u_portc (
    .clk      (clk),
    .rst      (rst),
    .mode_q   (mode_q),
    .mode_nxt (mode_nxt),
    .wr       (reg_wr && (reg_sel == SEL_C)),
    .wdata    (reg_wdata[PC_W-1:0]),
    .pc_in    (pc_in),
    .a_intr   (intr[0]),
    .a_bf     (bf[0]),
    .b_intr   (intr[1]),
    .b_bf     (bf[1]),
    .pc_out   (pc_out),
    .pc_oe    (pc_oe),
    .stb_a    (stb[0]),
    .stb_b    (stb[1]),
    .rd_val   (pc_rval)
  );

  assign pa_out = lane_out[0];
  assign pb_out = lane_out[1];
  assign pa_oe  = cmd_q[0];
  assign pb_oe  = cmd_q[1];

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_sel)
        SEL_CS:  reg_rdata <= {{(BUS_W-6){1'b0}}, cmd_q[INTE0+1], bf[1], intr[1],
                               cmd_q[INTE0], bf[0], intr[0]};
        SEL_A:   reg_rdata <= lane_rval[0];
        SEL_B:   reg_rdata <= lane_rval[1];
        default: reg_rdata <= {{(BUS_W-PC_W){1'b0}}, pc_rval};
      endcase
    end
  end
endmodule

// File: rtl/pport_ctrl_chk.sv
module pport_ctrl_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       reg_sel,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [BUS_W-1:0] reg_rdata,
  input logic [BUS_W-1:0] pa_out,
  input logic             pa_oe,
  input logic [5:0]       pc_in,
  input logic [5:0]       pc_out,
  input logic [5:0]       pc_oe
);
  logic hs_a;
  assign hs_a = (pc_oe == 6'h3B) || (pc_oe == 6'h1B);

  a_r5_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pa_oe == 1'b0 && pa_out == '0 && pc_oe == 6'h00 && reg_rdata == '0));

  a_r3_input_latch_zero: assert property (@(posedge clk) disable iff (rst)
    !pa_oe |-> (pa_out == '0));

  a_r2_pc_oe_legal: assert property (@(posedge clk) disable iff (rst)
    (pc_oe == 6'h00) || (pc_oe == 6'h3F) || (pc_oe == 6'h3B) || (pc_oe == 6'h1B));

  a_r7_bf_from_strobe: assert property (@(posedge clk) disable iff (rst)
    ($rose(pc_out[1]) && hs_a && $past(hs_a) && !pa_oe && $past(!pa_oe))
      |-> $past(!pc_in[2]));

  a_r8_bf_from_write: assert property (@(posedge clk) disable iff (rst)
    ($rose(pc_out[1]) && hs_a && $past(hs_a) && pa_oe && $past(pa_oe))
      |-> $past(reg_wr && reg_sel == 2'd1));

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_rd) |-> $stable(reg_rdata));
endmodule

bind pport_ctrl pport_ctrl_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .pa_out    (pa_out),
  .pa_oe     (pa_oe),
  .pc_in     (pc_in),
  .pc_out    (pc_out),
  .pc_oe     (pc_oe)
);

// File: tb/pport_ctrl_test.sv
module pport_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic [7:0] pa_in = 8'h00, pa_out, pb_in = 8'h00, pb_out;
  logic       pa_oe, pb_oe;
  logic [5:0] pc_in = 6'b100100, pc_out, pc_oe;

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       mon_arm = 1'b0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pport_ctrl uut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // monitor: a read sampled at a rising edge is compared at the next falling edge
  always @(posedge clk) mon_arm <= reg_rd;
  always @(negedge clk) begin
    if (mon_arm) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty actual=%h", reg_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s read actual=%h expected=%h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [1:0] sel, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_sel = sel; reg_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5 reset state
    chk({7'd0, pa_oe}, 8'h00, "R5 pa_oe");
    chk({7'd0, pb_oe}, 8'h00, "R5 pb_oe");
    chk({2'd0, pc_oe}, 8'h00, "R5 pc_oe");
    chk(pa_out, 8'h00, "R5 pa_out");

    // R3 write in input mode dropped, switch to output gives zeros
    wr_reg(2'd1, 8'hA5);
    wr_reg(2'd0, 8'h01);
    chk({7'd0, pa_oe}, 8'h01, "R1 pa_oe");
    chk(pa_out, 8'h00, "R3 dropped write");
    wr_reg(2'd1, 8'h3C);
    chk(pa_out, 8'h3C, "R3 output load");
    rd_expect(2'd1, 8'h3C, "R4 A output readback");
    pb_in = 8'h5A;
    rd_expect(2'd2, 8'h5A, "R4 B pin read");
    wr_reg(2'd0, 8'h00);
    chk(pa_out, 8'h00, "R3 cleared on input");
    wr_reg(2'd0, 8'h01);
    chk(pa_out, 8'h00, "R3 reenter output low");

    // R2 / R11 port C plain output
    wr_reg(2'd0, 8'h0C);
    chk({2'd0, pc_oe}, 8'h3F, "R2 plain out mask");
    wr_reg(2'd3, 8'h2A);
    chk({2'd0, pc_out}, 8'h2A, "R11 pc latch");
    rd_expect(2'd3, 8'h2A, "R4 C readback");
    wr_reg(2'd0, 8'h00);
    chk({2'd0, pc_oe}, 8'h00, "R2 plain in mask");
    wr_reg(2'd0, 8'h0C);
    chk({2'd0, pc_out}, 8'h00, "R3 C latch cleared");

    // R6 / R7 port A strobed input, interrupt enabled
    wr_reg(2'd0, 8'h14);
    chk({2'd0, pc_oe}, 8'h3B, "R2 A handshake mask");
    chk({2'd0, pc_out}, 8'h00, "R6 input initial levels");
    wr_reg(2'd3, 8'h38);
    chk({2'd0, pc_out}, 8'h38, "R11 PC3-5 plain");
    @(negedge clk); pa_in = 8'h77; pc_in[2] = 1'b0;
    @(negedge clk);
    chk({2'd0, pc_out}, 8'h3A, "R7 BF set by strobe");
    pa_in = 8'h11; pc_in[2] = 1'b1;
    @(negedge clk);
    chk({2'd0, pc_out}, 8'h3B, "R7 INTR on strobe rise");
    rd_expect(2'd0, 8'h07, "R9 status after strobe");
    rd_expect(2'd1, 8'h77, "R7 captured data");
    rd_expect(2'd0, 8'h04, "R7 flags cleared by read");
    chk({2'd0, pc_out}, 8'h38, "R7 pins after read");

    // R10 interrupt enable off
    wr_reg(2'd0, 8'h04);
    @(negedge clk); pa_in = 8'h99; pc_in[2] = 1'b0;
    @(negedge clk); pa_in = 8'h00; pc_in[2] = 1'b1;
    @(negedge clk);
    rd_expect(2'd0, 8'h02, "R10 BF only");
    rd_expect(2'd1, 8'h99, "R7 captured data 2");
    rd_expect(2'd0, 8'h00, "R10 cleared");

    // R6 / R8 port B strobed output
    wr_reg(2'd0, 8'h2A);
    chk({2'd0, pc_oe}, 8'h1B, "R2 AB handshake mask");
    chk({2'd0, pc_out}, 8'h08, "R6 output INTR high");
    chk({7'd0, pb_oe}, 8'h01, "R1 pb_oe");
    rd_expect(2'd0, 8'h28, "R9 status B");
    wr_reg(2'd2, 8'hC3);
    chk(pb_out, 8'hC3, "R8 B latch");
    chk({2'd0, pc_out}, 8'h10, "R8 write sets BF");
    rd_expect(2'd0, 8'h30, "R9 status B full");
    @(negedge clk); pc_in[5] = 1'b0;
    @(negedge clk);
    chk({2'd0, pc_out}, 8'h00, "R8 STB clears BF");
    pc_in[5] = 1'b1;
    @(negedge clk);
    chk({2'd0, pc_out}, 8'h08, "R8 INTR on rise");
    rd_expect(2'd0, 8'h28, "R9 status B done");

    repeat (3) @(negedge clk);
    chk(reg_rdata, 8'h28, "R12 rdata held");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard left %0d items", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule